// File: doc/BRIEF.md
# Command Ring Fetch Front End

This block sits at the head of a DMA engine and drains a circular command ring held in memory. Software programs the ring through a small register port: a control word with an enable, the ring size as a power of two in dwords, and a switch for read-pointer writeback. It also writes a 256-byte-aligned base, the two ring pointers and a 40-bit writeback address. The pointers are byte offsets of dwords.

While the ring is enabled and the read pointer differs from the write pointer, the block reads one dword at a time from a memory read port. The read address is the base plus four times the read index. Each dword goes to a downstream packet consumer over a valid/ready handshake. The read index advances when the consumer accepts the dword, and it wraps modulo the ring size.

When the consumer marks the end of a packet, the block can write the current read pointer to memory, with at most one write in flight. A status bit reports idle. A synchronous soft-reset input returns the whole block to its cleared state.

Top module: `cmdring_fetch`

## Requirements
- R1: While enabled (control bit 0) with read index != write index, the block fetches the dword at address {base[31:0], 8'h00} + 4*read_index and presents it on cmd_data, in ring order, one dword per accepted transfer.
- R2: The read index wraps to 0 after index 2^N - 1, where N is control bits [5:1].
- R3: Register 2 (read pointer) and register 3 (write pointer) are byte offsets (index in bits [IDX_W+1:2], bits 1:0 read as 0). The read pointer increases by 4 modulo the ring size per accepted dword.
- R4: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_data is unchanged.
- R5: Clearing control bit 0 stops fetching after the dword in flight is delivered. No new memory read starts, the pointers keep their values, and setting the bit again resumes from the stored read pointer.
- R6: With control bit 12 set, each pkt_end pulse causes one write of the then-current read pointer to address {wb_hi[7:0], wb_lo[31:2], 2'b00}, where wb_lo is register 4 and wb_hi is register 5. At most one write is outstanding, and wb_addr and wb_data are held until wb_ack.
- R7: With control bit 12 clear, pkt_end is ignored and no writeback is issued.
- R8: Status register 6 bit 0 reads 1 exactly when no memory read or delivery is in progress, the ring has no enabled pending work, and cons_idle is high.
- R9: A soft_rst cycle clears every register (control, base, both pointers, writeback address) to 0 and drops any in-flight fetch or writeback.
- R10: mem_rd_req is held high with a stable mem_rd_addr until mem_rd_valid returns data. Only one read is outstanding.
- R11: A memory read never starts unless, in the launching cycle, the ring was enabled and non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous engine clear |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 ctrl, 1 base, 2 rptr, 3 wptr, 4 wb low, 5 wb high, 6 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_rd_req | output | 1 | Memory read request, held until data |
| mem_rd_addr | output | 40 | Memory read byte address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| cmd_valid | output | 1 | Dword available to the consumer |
| cmd_data | output | 32 | Dword to the consumer |
| cmd_ready | input | 1 | Consumer accepts the dword |
| cons_idle | input | 1 | Consumer has no work |
| pkt_end | input | 1 | Consumer finished a packet |
| wb_req | output | 1 | Read-pointer writeback request |
| wb_addr | output | 40 | Writeback byte address |
| wb_data | output | 32 | Read pointer being written back |
| wb_ack | input | 1 | Writeback accepted |

## Verification
The hardest states to reach from the ports are the ones where a control change lands while a dword is in flight. Examples are the enable being cleared between a memory request and its delivery, and a soft reset arriving mid-stream. The bench polls the read pointer through the register port until the stream has passed a chosen index, then acts, so the change falls while fetching is still running. Wrap is reached by programming a read pointer near the top of a small ring. Writeback ordering is exercised by pulsing pkt_end on the same cycle as a dword handshake. The pointer written back must then already include that dword.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int ADDR_W      = 40;
  localparam int SZ_W        = 5;
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_SZ_LSB = 1;
  localparam int CTRL_WB_BIT = 12;
  localparam int WB_HI_W     = ADDR_W - 32;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;

  typedef enum logic [1:0] {FS_IDLE, FS_READ, FS_HOLD} fetch_st_e;
endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              advance,
  input  logic              idle,
  output logic [31:0]       reg_rdata,
  output logic              ring_en,
  output logic              wb_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [31:0]       base_q,
  output logic [ADDR_W-1:0] wb_addr
);
  logic              en_q, en_d, wbe_q, wbe_d;
  logic [SZ_W-1:0]   sz_q, sz_d;
  logic [31:0]       base_d;
  logic [IDX_W-1:0]  rd_q, rd_d, wr_q, wr_d, idx_mask;
  logic [29:0]       wblo_q, wblo_d;
  logic [WB_HI_W-1:0] wbhi_q, wbhi_d;
  logic              upd;

  always_comb begin
    if (int'(sz_q) >= IDX_W) idx_mask = '1;
    else idx_mask = (IDX_W'(1) << sz_q) - IDX_W'(1);
  end

  always_comb begin
    en_d = en_q; wbe_d = wbe_q; sz_d = sz_q; base_d = base_q;
    rd_d = rd_q; wr_d = wr_q; wblo_d = wblo_q; wbhi_d = wbhi_q;
    if (advance) rd_d = (rd_q + IDX_W'(1)) & idx_mask;
    if (reg_we) begin
      unique case (reg_addr)
        RA_CTRL: begin
          en_d  = reg_wdata[CTRL_EN_BIT];
          sz_d  = reg_wdata[CTRL_SZ_LSB +: SZ_W];
          wbe_d = reg_wdata[CTRL_WB_BIT];
        end
        RA_BASE: base_d = reg_wdata;
        RA_RPTR: rd_d   = reg_wdata[IDX_W+1:2];
        RA_WPTR: wr_d   = reg_wdata[IDX_W+1:2];
        RA_WBLO: wblo_d = reg_wdata[31:2];
        RA_WBHI: wbhi_d = reg_wdata[WB_HI_W-1:0];
        default: ;
      endcase
    end
    if (soft_rst) begin
      en_d = 1'b0; wbe_d = 1'b0; sz_d = '0; base_d = '0;
      rd_d = '0; wr_d = '0; wblo_d = '0; wbhi_d = '0;
    end
  end

  assign upd = soft_rst | reg_we | advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; wbe_q <= 1'b0; sz_q <= '0; base_q <= '0;
      rd_q <= '0; wr_q <= '0; wblo_q <= '0; wbhi_q <= '0;
    end else if (upd) begin
      en_q <= en_d; wbe_q <= wbe_d; sz_q <= sz_d; base_q <= base_d;
      rd_q <= rd_d; wr_q <= wr_d; wblo_q <= wblo_d; wbhi_q <= wbhi_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CTRL_EN_BIT]           = en_q;
        reg_rdata[CTRL_SZ_LSB +: SZ_W]   = sz_q;
        reg_rdata[CTRL_WB_BIT]           = wbe_q;
      end
      RA_BASE: reg_rdata = base_q;
      RA_RPTR: reg_rdata = 32'({rd_q, 2'b00});
      RA_WPTR: reg_rdata = 32'({wr_q, 2'b00});
      RA_WBLO: reg_rdata = {wblo_q, 2'b00};
      RA_WBHI: reg_rdata = 32'(wbhi_q);
      RA_STAT: reg_rdata = {31'd0, idle};
      default: reg_rdata = '0;
    endcase
  end

  assign ring_en = en_q;
  assign wb_en   = wbe_q;
  assign rd_idx  = rd_q;
  assign wr_idx  = wr_q;
  assign wb_addr = {wbhi_q, wblo_q, 2'b00};

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_q == '0) && (wr_q == '0) && !en_q && !wbe_q) else $error("soft reset"); // R9
endmodule

// File: rtl/cmdring_reader.sv
module cmdring_reader
  import cmdring_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ring_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       base_q,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              cmd_valid,
  output logic [31:0]       cmd_data,
  input  logic              cmd_ready,
  output logic              advance,
  output logic              busy
);
  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, launch_addr;
  logic [31:0]       data_q, data_d;
  logic              addr_ld, data_ld;

  assign launch_addr = ADDR_W'({base_q, 8'h00}) + ADDR_W'({rd_idx, 2'b00});

  always_comb begin
    st_d = st_q; addr_d = addr_q; data_d = data_q; advance = 1'b0;
    unique case (st_q)
      FS_IDLE: if (ring_en && (rd_idx != wr_idx)) begin
        st_d = FS_READ; addr_d = launch_addr;
      end
      FS_READ: if (mem_rd_valid) begin
        st_d = FS_HOLD; data_d = mem_rd_data;
      end
      FS_HOLD: if (cmd_ready) begin
        st_d = FS_IDLE; advance = 1'b1;
      end
      default: st_d = FS_IDLE;
    endcase
    if (soft_rst) begin
      st_d = FS_IDLE; advance = 1'b0;
    end
  end

  assign addr_ld = (st_q == FS_IDLE);
  assign data_ld = (st_q == FS_READ) && mem_rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; data_q <= '0;
    end else begin
      if (addr_ld) addr_q <= addr_d;
      if (data_ld) data_q <= data_d;
    end
  end

  assign mem_rd_req  = (st_q == FS_READ);
  assign mem_rd_addr = addr_q;
  assign cmd_valid   = (st_q == FS_HOLD);
  assign cmd_data    = data_q;
  assign busy        = (st_q != FS_IDLE);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid && !soft_rst) |=> mem_rd_req && $stable(mem_rd_addr)) else $error("mem hold"); // R10
  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> $past(ring_en && (rd_idx != wr_idx))) else $error("fetch gated"); // R11
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !soft_rst) |=> cmd_valid && $stable(cmd_data)) else $error("cmd hold"); // R4
  AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && cmd_valid)) else $error("read while holding"); // R10
endmodule

// File: rtl/cmdring_ptr_wb.sv
module cmdring_ptr_wb
  import cmdring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wb_en,
  input  logic              pkt_end,
  input  logic [31:0]       rptr_bytes,
  input  logic [ADDR_W-1:0] wb_addr_in,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_data,
  input  logic              wb_ack
);
  logic              pend_q, pend_d, busy_q, busy_d, issue;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] addr_q;

  assign issue = !busy_q && pend_q && wb_en && !soft_rst;

  always_comb begin
    pend_d = pend_q | (pkt_end & wb_en);
    busy_d = busy_q;
    if (issue) begin
      busy_d = 1'b1;
      pend_d = pkt_end & wb_en;
    end
    if (busy_q && wb_ack) busy_d = 1'b0;
    if (!wb_en) pend_d = 1'b0;
    if (soft_rst) begin
      pend_d = 1'b0; busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d; busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; addr_q <= '0;
    end else if (issue) begin
      data_q <= rptr_bytes; addr_q <= wb_addr_in;
    end
  end

  assign wb_req  = busy_q;
  assign wb_addr = addr_q;
  assign wb_data = data_q;

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack && !soft_rst) |=> wb_req && $stable(wb_data) && $stable(wb_addr)) else $error("wb hold"); // R6
  AST_WB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_en |=> !$rose(wb_req)) else $error("wb while off"); // R7
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
  import cmdring_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd_req,
  output logic [39:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        cmd_valid,
  output logic [31:0] cmd_data,
  input  logic        cmd_ready,
  input  logic        cons_idle,
  input  logic        pkt_end,
  output logic        wb_req,
  output logic [39:0] wb_addr,
  output logic [31:0] wb_data,
  input  logic        wb_ack
);
  logic              ring_en, wb_en, advance, rd_busy, idle;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [31:0]       base_q;
  logic [ADDR_W-1:0] wb_addr_cfg;

  assign idle = !rd_busy && !(ring_en && (rd_idx != wr_idx)) && cons_idle;

  cmdring_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .advance(advance), .idle(idle), .reg_rdata(reg_rdata),
    .ring_en(ring_en), .wb_en(wb_en), .rd_idx(rd_idx), .wr_idx(wr_idx),
    .base_q(base_q), .wb_addr(wb_addr_cfg)
  );

  cmdring_reader #(.IDX_W(IDX_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ring_en(ring_en), .rd_idx(rd_idx), .wr_idx(wr_idx), .base_q(base_q),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .advance(advance), .busy(rd_busy)
  );

  cmdring_ptr_wb u_wb (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wb_en(wb_en), .pkt_end(pkt_end),
    .rptr_bytes(32'({rd_idx, 2'b00})), .wb_addr_in(wb_addr_cfg),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_rd_req && !cmd_valid) else $error("idle while busy"); // R8
endmodule

// File: tb/test_cmdring_fetch.sv
module test_cmdring_fetch;
  localparam logic [2:0] A_CTRL = 3'd0, A_BASE = 3'd1, A_RPTR = 3'd2, A_WPTR = 3'd3;
  localparam logic [2:0] A_WBLO = 3'd4, A_WBHI = 3'd5, A_STAT = 3'd6;
  localparam logic [39:0] WBA = {8'h3C, 32'h0000_1004};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, soft_rst = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_rd_req, mem_rd_valid = 1'b0;
  logic [39:0] mem_rd_addr, wb_addr;
  logic [31:0] mem_rd_data = '0, cmd_data, wb_data;
  logic        cmd_valid, cmd_ready = 1'b0, cons_idle = 1'b1, pkt_end = 1'b0;
  logic        wb_req, wb_ack = 1'b0;

  cmdring_fetch i_cmdring_fetch (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .cons_idle(cons_idle), .pkt_end(pkt_end), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack)
  );

  int vecs = 0, bad = 0, cyc = 0, hs_cnt = 0, wb_writes = 0, mem_cnt = 0, wb_cnt = 0;
  int ready_pat = 0;
  bit pkt_mode = 0, wb_on = 0, prev_stall = 0, done = 0;
  logic [31:0] prev_data = '0;
  logic [31:0] exp_q[$];
  logic [31:0] nxt_q[$];
  logic [31:0] wbexp_q[$];

  function automatic logic [31:0] mem_fn(input logic [39:0] a);
    return a[33:2] ^ {a[39:34], 26'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  task automatic push_range(input logic [31:0] base, input int start, input int cnt, input int lg);
    for (int i = 0; i < cnt; i++) begin
      int idx, nidx;
      idx  = (start + i) & ((1 << lg) - 1);
      nidx = (idx + 1) & ((1 << lg) - 1);
      exp_q.push_back(mem_fn({base, 8'h00} + 40'(idx * 4)));
      nxt_q.push_back(32'(nidx * 4));
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_rptr(input logic [31:0] target, input bit at_least, input string req);
    logic [31:0] d;
    bit hit = 0;
    for (int i = 0; i < 4000 && !hit; i++) begin
      reg_read(A_RPTR, d);
      if (at_least ? (d >= target) : (d == target)) hit = 1;
    end
    chk(hit, req, d, target);
  endtask

  // consumer monitor: pops the scoreboard on every handshake
  always @(negedge clk) begin
    logic [31:0] e, n;
    cyc++;
    if (!rst_n) begin
      cmd_ready = 1'b0; pkt_end = 1'b0; prev_stall = 0;
    end else begin
      if (prev_stall) chk(cmd_valid && (cmd_data == prev_data), "R4 stalled dword held", cmd_data, prev_data);
      cmd_ready = (ready_pat == 0) ? 1'b1 : ((cyc % 3) != 1);
      pkt_end = 1'b0;
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected dword", cmd_data, 0);
        else begin
          e = exp_q.pop_front(); n = nxt_q.pop_front();
          chk(cmd_data == e, "R1/R2 dword content", cmd_data, e);
          hs_cnt++;
          if (pkt_mode && (hs_cnt % 4 == 0)) begin
            pkt_end = 1'b1;
            if (wb_on) wbexp_q.push_back(n);
          end
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_data  = cmd_data;
    end
  end

  // memory read responder, latency 2
  always @(negedge clk) begin
    if (mem_rd_valid) mem_rd_valid = 1'b0;
    else if (mem_rd_req) begin
      if (mem_cnt == 2) begin
        mem_rd_valid = 1'b1; mem_rd_data = mem_fn(mem_rd_addr); mem_cnt = 0;
      end else mem_cnt++;
    end else mem_cnt = 0;
  end

  // writeback responder
  always @(negedge clk) begin
    logic [31:0] e;
    if (wb_ack) wb_ack = 1'b0;
    else if (wb_req) begin
      if (wb_cnt == 1) begin
        wb_ack = 1'b1; wb_cnt = 0; wb_writes++;
        chk(wb_addr == WBA, "R6 writeback address", wb_addr, WBA);
        if (wbexp_q.size() == 0) chk(0, "R6/R7 unexpected writeback", wb_data, 0);
        else begin
          e = wbexp_q.pop_front();
          chk(wb_data == e, "R6 writeback pointer", wb_data, e);
        end
      end else wb_cnt++;
    end else wb_cnt = 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R1 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d, p1, p2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!cmd_valid && !mem_rd_req && !wb_req, "R9 outputs quiet after reset", {cmd_valid, mem_rd_req, wb_req}, 0);
    reg_read(A_RPTR, d); chk(d == 0, "R3 read pointer reset", d, 0);
    reg_read(A_CTRL, d); chk(d == 0, "R9 control reset", d, 0);
    reg_read(A_STAT, d); chk(d == 1, "R8 idle after reset", d, 1);

    // basic stream, 16-dword ring
    reg_write(A_BASE, 32'h0012_3456);
    reg_write(A_CTRL, 32'd8);
    reg_write(A_RPTR, 0);
    reg_write(A_WPTR, 20);
    push_range(32'h0012_3456, 0, 5, 4);
    reg_write(A_CTRL, 32'd9);
    reg_read(A_STAT, d); chk(d == 0, "R8 busy while work pending", d, 0);
    wait_rptr(20, 0, "R3 read pointer after 5 dwords");
    reg_read(A_RPTR, d); chk(d[1:0] == 0, "R3 pointer low bits zero", d, 20);
    chk(exp_q.size() == 0, "R1 all dwords delivered", exp_q.size(), 0);
    reg_read(A_STAT, d); chk(d == 1, "R8 idle when drained", d, 1);

    // wrap: indices 14,15,0,1,2
    reg_write(A_CTRL, 32'd8);
    reg_write(A_RPTR, 14 * 4);
    reg_write(A_WPTR, 3 * 4);
    push_range(32'h0012_3456, 14, 5, 4);
    reg_write(A_CTRL, 32'd9);
    wait_rptr(12, 0, "R2 read pointer wrapped");
    chk(exp_q.size() == 0, "R2 wrapped dwords delivered", exp_q.size(), 0);

    // back-pressure
    ready_pat = 1;
    push_range(32'h0012_3456, 3, 8, 4);
    reg_write(A_WPTR, 11 * 4);
    wait_rptr(44, 0, "R4 stream under back-pressure");
    ready_pat = 0;

    // disable mid-stream, 64-dword ring
    reg_write(A_CTRL, 32'd12);
    reg_write(A_RPTR, 0);
    reg_write(A_WPTR, 40 * 4);
    push_range(32'h0012_3456, 0, 40, 6);
    reg_write(A_CTRL, 32'd13);
    wait_rptr(32, 1, "R5 stream started");
    reg_write(A_CTRL, 32'd12);
    repeat (10) @(negedge clk);
    reg_read(A_RPTR, p1);
    repeat (10) @(negedge clk);
    reg_read(A_RPTR, p2);
    chk(p1 == p2, "R5 pointer stable while disabled", p2, p1);
    chk(!mem_rd_req && !cmd_valid, "R5 no fetch while disabled", {mem_rd_req, cmd_valid}, 0);
    chk(p1 < 160, "R5 stopped before end", p1, 160);
    reg_read(A_STAT, d); chk(d == 1, "R8 idle while disabled", d, 1);
    reg_write(A_CTRL, 32'd13);
    wait_rptr(160, 0, "R5 resumed to end");
    chk(exp_q.size() == 0, "R5 remaining dwords delivered", exp_q.size(), 0);

    // writeback enabled
    reg_write(A_WBLO, 32'h0000_1007);
    reg_write(A_WBHI, 32'h0000_013C);
    reg_read(A_WBLO, d); chk(d == 32'h1004, "R6 writeback low word aligned", d, 32'h1004);
    reg_write(A_CTRL, 32'd12);
    reg_write(A_RPTR, 0);
    reg_write(A_WPTR, 16 * 4);
    push_range(32'h0012_3456, 0, 16, 6);
    hs_cnt = 0; pkt_mode = 1; wb_on = 1;
    reg_write(A_CTRL, 32'd13 | (32'd1 << 12));
    wait_rptr(64, 0, "R6 stream with packets");
    repeat (10) @(negedge clk);
    chk(wb_writes == 4, "R6 one write per packet", wb_writes, 4);
    chk(wbexp_q.size() == 0, "R6 all writebacks seen", wbexp_q.size(), 0);

    // writeback disabled
    wb_on = 0;
    reg_write(A_CTRL, 32'd12);
    push_range(32'h0012_3456, 16, 8, 6);
    reg_write(A_WPTR, 24 * 4);
    reg_write(A_CTRL, 32'd13);
    wait_rptr(96, 0, "R7 stream without writeback");
    repeat (10) @(negedge clk);
    chk(wb_writes == 4, "R7 pkt_end ignored", wb_writes, 4);
    pkt_mode = 0;

    // consumer busy
    cons_idle = 1'b0;
    reg_read(A_STAT, d); chk(d == 0, "R8 consumer busy not idle", d, 0);
    cons_idle = 1'b1;
    reg_read(A_STAT, d); chk(d == 1, "R8 consumer idle", d, 1);

    // soft reset mid-stream
    push_range(32'h0012_3456, 24, 36, 6);
    reg_write(A_WPTR, 60 * 4);
    wait_rptr(27 * 4, 1, "R9 stream before soft reset");
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    exp_q.delete(); nxt_q.delete();
    #1 chk(!cmd_valid && !mem_rd_req, "R9 in-flight work dropped", {cmd_valid, mem_rd_req}, 0);
    reg_read(A_RPTR, d); chk(d == 0, "R9 read pointer cleared", d, 0);
    reg_read(A_WPTR, d); chk(d == 0, "R9 write pointer cleared", d, 0);
    reg_read(A_CTRL, d); chk(d == 0, "R9 control cleared", d, 0);
    reg_read(A_BASE, d); chk(d == 0, "R9 base cleared", d, 0);
    repeat (20) @(negedge clk);
    reg_read(A_STAT, d); chk(d == 1, "R9 idle after soft reset", d, 1);

    // restart after soft reset
    push_range(32'h0, 0, 2, 4);
    reg_write(A_WPTR, 8);
    reg_write(A_CTRL, 32'd9);
    wait_rptr(8, 0, "R9 restart after soft reset");
    chk(exp_q.size() == 0, "R1 restart dwords delivered", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule